// File: doc/BRIEF.md
# Terminal-Count Periodic Pulse Generator

This block produces a one-cycle pulse once every `PERIOD` enabled clock cycles. A loadable counter sets the rhythm. When the counter reaches its terminal value, the same signal raises the output pulse and selects the reload value into the counter. The period therefore comes from the reload point and not from the counter's natural binary wrap. A typical use is to slow a fast tick down to a slower event rate. The default build divides by nine. An up-counting build with `PERIOD = 60` turns a 60 Hz tick into a once-per-second pulse.

A build parameter selects the counting direction:

- **Down build:** the counter starts at `PERIOD-1`, steps down to zero, and then reloads `PERIOD-1`.
- **Up build:** the counter starts at zero, steps up to `PERIOD-1`, and then clears to zero.

In both builds the counter width is the smallest that holds `PERIOD-1`. The enable input works as a clock enable. While it is low the count is frozen and no pulse is produced.

The reset input is asynchronous and active low. It is released through a local synchronizer, so its release reaches the counter two clock edges after the input rises.

Top module: `periodic_pulse_gen`

## Requirements
- R1: `pulse_o` is high in exactly one of every `PERIOD` consecutive enabled cycles. Counting enabled cycles from 1 after reset, the pulse falls on enabled cycle `PERIOD`, `2*PERIOD`, and so on.
- R2: In the down build (`DIR = DIR_DOWN`), each enabled cycle that is not terminal lowers the count by one. The count runs `PERIOD-1`, `PERIOD-2`, ..., 0, giving nine states, 8 down to 0, for the default `PERIOD = 9`.
- R3: In an enabled cycle at the terminal value, the next count is the reload value instead of the stepped value. The terminal value is 0 in the down build and `PERIOD-1` in the up build. The reload value is `PERIOD-1` in the down build and 0 in the up build.
- R4: While `en_i` is low, the count holds its value, `pulse_o` stays low, and the phase of later pulses is unchanged.
- R5: In the up build (`DIR = DIR_UP`), each enabled cycle that is not terminal raises the count by one. For `PERIOD = 60` this gives one pulse per 60 enabled input ticks.
- R6: The count always stays within 0 to `PERIOD-1`. The counter width is `ceil(log2(PERIOD))` bits, with a minimum of 1.
- R7: Driving `rst_ni` low sets the counter to its start value at once: `PERIOD-1` when counting down, 0 when counting up. The release takes effect after two rising clock edges. The first pulse after reset falls on the `PERIOD`-th enabled cycle.
- R8: `pulse_o` is combinational in the current cycle. It is high only when the count is at the terminal value and `en_i` is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Clock enable for the counter and qualifier of the pulse |
| pulse_o | output | 1 | One-cycle pulse at the terminal count |

## Verification
Two builds run side by side:

- a down-counting build with period nine;
- an up-counting build with period sixty.

Each build has its own enable stream, and a reference model counts enabled cycles.

Long runs with the enable held high establish the basic period. Random enables with about seventy percent duty show the following:

- whether idle cycles freeze the phase;
- whether idle cycles are wrongly counted;
- whether a pulse leaks while the enable is low.

A reset asserted mid-period separates a correct start value from an off-by-one start. An off-by-one start would shift the first pulse after reset by one cycle.

// File: rtl/pulsegen_pkg.sv
package pulsegen_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/pg_reset_sync.sv
module pg_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/pg_tc_detect.sv
module pg_tc_detect
  import pulsegen_pkg::*;
#(
  parameter int unsigned W      = 4,
  parameter int unsigned PERIOD = 9,
  parameter dir_e        DIR    = DIR_DOWN
) (
  input  logic [W-1:0] cnt_i,
  output logic         tc_o
);
  localparam logic [W-1:0] LastV = W'(PERIOD - 1);

  generate
    if (DIR == DIR_DOWN) begin : g_down
      assign tc_o = (cnt_i == '0);
    end else begin : g_up
      assign tc_o = (cnt_i == LastV);
    end
  endgenerate
endmodule

// File: rtl/pg_counter.sv
module pg_counter
  import pulsegen_pkg::*;
#(
  parameter int unsigned W      = 4,
  parameter int unsigned PERIOD = 9,
  parameter dir_e        DIR    = DIR_DOWN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LastV   = W'(PERIOD - 1);
  localparam logic [W-1:0] ReloadV = (DIR == DIR_DOWN) ? LastV : '0;

  logic [W-1:0] cnt_q;
  logic [W-1:0] step_val;
  logic [W-1:0] cnt_d;

  generate
    if (DIR == DIR_DOWN) begin : g_dec
      assign step_val = cnt_q - W'(1);
    end else begin : g_inc
      assign step_val = cnt_q + W'(1);
    end
  endgenerate

  // 2:1 select between stepped value and reload value
  always_comb begin
    cnt_d = tc_i ? ReloadV : step_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= ReloadV;
    else if (en_i) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/periodic_pulse_gen.sv
module periodic_pulse_gen
  import pulsegen_pkg::*;
#(
  parameter int unsigned PERIOD      = 9,
  parameter dir_e        DIR         = DIR_DOWN,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic pulse_o
);
  localparam int unsigned W = (PERIOD <= 2) ? 1 : $clog2(PERIOD);

  logic         rst_sync_n;
  logic [W-1:0] cnt_q;
  logic         tc;

  pg_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .rst_no (rst_sync_n)
  );

  pg_counter #(.W(W), .PERIOD(PERIOD), .DIR(DIR)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .en_i  (en_i),
    .tc_i  (tc),
    .cnt_o (cnt_q)
  );

  pg_tc_detect #(.W(W), .PERIOD(PERIOD), .DIR(DIR)) u_tc (
    .cnt_i(cnt_q),
    .tc_o (tc)
  );

  assign pulse_o = tc & en_i;
endmodule

// File: rtl/pg_checker.sv
module pg_checker
  import pulsegen_pkg::*;
#(
  parameter int unsigned W      = 4,
  parameter int unsigned PERIOD = 9,
  parameter dir_e        DIR    = DIR_DOWN
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic         en_i,
  input logic         pulse_o,
  input logic [W-1:0] cnt_i
);
  localparam logic [W-1:0] LastV   = W'(PERIOD - 1);
  localparam logic [W-1:0] ReloadV = (DIR == DIR_DOWN) ? LastV : '0;

  // enabled cycles since the last pulse (or since reset)
  int unsigned gap_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) gap_q <= 0;
    else if (en_i) gap_q <= pulse_o ? 0 : gap_q + 1;
  end

  p_period_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    pulse_o |-> gap_q == PERIOD - 1);
  p_due_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_i && gap_q == PERIOD - 1) |-> pulse_o);
  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    pulse_o |=> cnt_i == ReloadV);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> $stable(cnt_i));
  p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |-> !pulse_o);
  p_range_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt_i <= LastV);

  generate
    if (DIR == DIR_DOWN) begin : g_down
      p_step_down_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
        (en_i && !pulse_o) |=> cnt_i == $past(cnt_i) - W'(1));
    end else begin : g_up
      p_step_up_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
        (en_i && !pulse_o) |=> cnt_i == $past(cnt_i) + W'(1));
    end
  endgenerate
endmodule

bind periodic_pulse_gen pg_checker #(.W(W), .PERIOD(PERIOD), .DIR(DIR)) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_sync_n),
  .en_i   (en_i),
  .pulse_o(pulse_o),
  .cnt_i  (cnt_q)
);

// File: tb/sim_periodic_pulse_gen.sv
module sim_periodic_pulse_gen;
  import pulsegen_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int P0 = 9;
  localparam int P1 = 60;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en0 = 1'b0;
  logic en1 = 1'b0;
  logic pulse0, pulse1;

  int tests = 0;
  int fails = 0;
  int k0 = 0;
  int k1 = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_pulse_gen #(.PERIOD(P0), .DIR(DIR_DOWN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en0), .pulse_o(pulse0));
  periodic_pulse_gen #(.PERIOD(P1), .DIR(DIR_UP)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en1), .pulse_o(pulse1));

  function automatic bit exp_pulse(int k, int n, bit en);
    return en && (k == n - 1);
  endfunction

  task automatic check(string req, bit act, bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pulse actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // one cycle: drive enables at the falling edge, check before the rising edge
  task automatic step(bit e0, bit e1, string req0, string req1);
    @(negedge clk);
    en0 = e0;
    en1 = e1;
    #1;
    check(req0, pulse0, exp_pulse(k0, P0, e0));
    check(req1, pulse1, exp_pulse(k1, P1, e1));
    if (e0) k0 = (k0 + 1) % P0;
    if (e1) k1 = (k1 + 1) % P1;
  endtask

  task automatic do_reset(int hold);
    @(negedge clk);
    en0 = 1'b0;
    en1 = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R7 reset", pulse0, 1'b0);
    check("R7 reset", pulse1, 1'b0);
    repeat (hold) @(negedge clk);
    rst_n = 1'b1;
    k0 = 0;
    k1 = 0;
    // idle cycles while the synchronized release propagates
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R7 idle", "R7 idle");
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset(3);

    // R1 R2 R3: continuous enable, down build; R5 up build
    for (int i = 0; i < 3 * P1; i++) step(1'b1, 1'b1, "R1 R2 R3", "R1 R5 R3");

    // R8: enable dropped exactly at the terminal cycle
    while (k0 != P0 - 1) step(1'b1, 1'b0, "R8", "R4");
    step(1'b0, 1'b0, "R8 R4", "R4");
    step(1'b1, 1'b0, "R8", "R4");

    // R4: random enables, about 70 percent duty
    for (int i = 0; i < 3000; i++)
      step(($urandom % 10) < 7, ($urandom % 10) < 7, "R4 R1", "R4 R5");

    // R7: reset asserted mid-period, first pulse a full period later
    while (k0 != 4) step(1'b1, 1'b1, "R1", "R5");
    do_reset(2);
    for (int i = 0; i < 2 * P1; i++) step(1'b1, 1'b1, "R7 R2", "R7 R5");

    // R6: long random run checks no out-of-range phase appears
    for (int i = 0; i < 1000; i++)
      step(($urandom % 4) != 0, ($urandom % 4) != 0, "R6 R2", "R6 R5");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    while (!done && cycles < MAX_CYCLES) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule